// File: doc/BRIEF.md
# Interrupt Message Claim Unit

This block sits on a processor bus agent and watches memory-write interrupt messages. Each message arrives as one strobe with a 32-bit address and a 32-bit data word. The unit checks that the address falls in the interrupt window. It extracts the target identifier and the delivery fields, then decides whether this agent takes the message under physical destination addressing.

The agent's identity is an 8-bit local ID register. At reset, its low five bits are assembled from strap pins (thread, agent and cluster subfields) and its upper bits are cleared. Software may replace the whole register at any time after reset. A target of all ones is taken by every agent and is flagged as a broadcast. A message that asks for logical addressing is not taken. Instead it raises a one-cycle "unsupported" pulse. All outputs are registered and appear one clock after the message strobe.

Top module: `irq_claim_unit`

## Requirements
- R1: A message is considered only when address bits [31:20] equal 0xFEE; any other address gives neither a claim nor an unsupported pulse.
- R2: The target ID is address bits [19:12]; address bits [11:4] have no effect on the outcome.
- R3: On a claim, the vector output carries data bits [7:0], the delivery-mode output data bits [10:8] and the trigger output data bit [15]; data bit [14] is not reflected; all three field outputs are zero when no claim is made.
- R4: A target ID of 0xFF is claimed regardless of the local ID, with the broadcast flag set in the same cycle as the claim.
- R5: A physical-mode message whose target ID equals the local ID is claimed with the broadcast flag low; any other non-0xFF target is not claimed.
- R6: Reset clears all outputs and loads the local ID as {3'b000, cluster[1:0], agent[1:0], thread}, i.e. thread in bit 0, agent in bits [2:1], cluster in bits [4:3].
- R7: A software write replaces all 8 bits of the local ID; messages in later cycles are matched against the written value.
- R8: When a software write and a message occur in the same cycle, the message is matched against the ID held before the write.
- R9: Address bit 2 set (logical mode) on an in-window message gives no claim and a one-cycle unsupported pulse.
- R10: Claim and unsupported outputs rise exactly one clock after the message strobe and last one cycle for each message; back-to-back messages give back-to-back results.
- R11: Address bit 3 (redirection hint) has no effect on whether a message is claimed.
- R12: In a cycle without a message strobe, the next cycle shows no claim and no unsupported pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cluster | input | 2 | Cluster subfield loaded into ID bits [4:3] at reset |
| strap_agent | input | 2 | Agent subfield loaded into ID bits [2:1] at reset |
| strap_thread | input | 1 | Thread subfield loaded into ID bit 0 at reset |
| id_wr_en | input | 1 | Software write strobe for the local ID |
| id_wr_data | input | 8 | New local ID value |
| msg_valid | input | 1 | Interrupt message write strobe |
| msg_addr | input | 32 | Message address |
| msg_data | input | 32 | Message data |
| claim_valid | output | 1 | One-cycle claim strobe |
| claim_vector | output | 8 | Claimed vector |
| claim_dlv_mode | output | 3 | Claimed delivery mode |
| claim_trigger | output | 1 | Claimed trigger mode |
| claim_bcast | output | 1 | Claim came from a broadcast target |
| unsup_mode | output | 1 | One-cycle pulse for a logical-mode message |

## Verification
The local ID is the only long-lived state. A corrupted or stale ID shows up at the ports on the first directed message after the fault: an expected claim goes missing, or an unexpected one appears, one clock after the strobe. Broadcasts still pass, so the bench mixes directed hits, near misses and broadcasts, and also probes the old and new IDs around each write. Field-slicing errors show on the first claimed message in the vector, delivery-mode or trigger outputs.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
   localparam int VEC_W  = 8;
   localparam int MODE_W = 3;

   typedef struct packed {
      logic [VEC_W-1:0]  vector;
      logic [MODE_W-1:0] dlv_mode;
      logic              trigger;
   } irq_fields_t;
endpackage

// File: rtl/irq_msg_decode.sv
module irq_msg_decode
   import irq_claim_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 8,
   parameter int WIN_W  = 12,
   parameter logic [WIN_W-1:0] WIN_BASE = 12'hFEE,
   parameter int LOGIC_BIT = 2,
   parameter int TRIG_BIT  = 15
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              in_window,
   output logic              logical,
   output logic [ID_W-1:0]   dest_id,
   output irq_fields_t       fields
);
   localparam int DEST_LSB = ADDR_W - WIN_W - ID_W;
   localparam int MODE_LSB = VEC_W;

   if (DEST_LSB <= LOGIC_BIT) begin : g_bad_layout
      $error("irq_msg_decode: destination field overlaps mode bit");
   end
   if (TRIG_BIT >= DATA_W || MODE_LSB + MODE_W > TRIG_BIT) begin : g_bad_data
      $error("irq_msg_decode: data field layout does not fit");
   end

   assign in_window       = (addr[ADDR_W-1 -: WIN_W] == WIN_BASE);
   assign dest_id         = addr[DEST_LSB +: ID_W];
   assign logical         = addr[LOGIC_BIT];
   assign fields.vector   = data[VEC_W-1:0];
   assign fields.dlv_mode = data[MODE_LSB +: MODE_W];
   assign fields.trigger  = data[TRIG_BIT];

   logic unused_bits;
   assign unused_bits = ^{addr[DEST_LSB-1:LOGIC_BIT+1], addr[LOGIC_BIT-1:0],
                          data[DATA_W-1:TRIG_BIT+1], data[TRIG_BIT-1:MODE_LSB+MODE_W]};
endmodule

// File: rtl/irq_local_id.sv
module irq_local_id #(
   parameter int ID_W = 8,
   parameter int CL_W = 2,
   parameter int AG_W = 2,
   parameter int TH_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CL_W-1:0] strap_cluster,
   input  logic [AG_W-1:0] strap_agent,
   input  logic [TH_W-1:0] strap_thread,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_data,
   output logic [ID_W-1:0] id_q
);
   localparam int STRAP_W = CL_W + AG_W + TH_W;

   if (STRAP_W > ID_W) begin : g_bad_straps
      $error("irq_local_id: strap subfields wider than ID");
   end

   logic [ID_W-1:0] reset_id;
   if (STRAP_W == ID_W) begin : g_full
      assign reset_id = {strap_cluster, strap_agent, strap_thread};
   end else begin : g_pad
      assign reset_id = {{(ID_W-STRAP_W){1'b0}}, strap_cluster, strap_agent, strap_thread};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_q <= reset_id;
      else if (wr_en) id_q <= wr_data;
   end

   // R7: a write lands in full on the next edge
   p_id_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en)) |-> (id_q == $past(wr_data)));
   // R7: without a write the ID holds
   p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en)) |-> $stable(id_q));
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
   parameter int ID_W     = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [ID_W-1:0] dest_id,
   input  logic [ID_W-1:0] local_id,
   output logic            hit,
   output logic            bcast
);
   logic direct;
   assign direct = (dest_id == local_id);

   if (BCAST_EN) begin : g_bcast
      assign bcast = &dest_id;
      assign hit   = direct | bcast;
   end else begin : g_no_bcast
      assign bcast = 1'b0;
      assign hit   = direct;
   end
endmodule

// File: rtl/irq_claim_unit.sv
module irq_claim_unit
   import irq_claim_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 8,
   parameter int CL_W   = 2,
   parameter int AG_W   = 2,
   parameter int WIN_W  = 12,
   parameter logic [WIN_W-1:0] WIN_BASE = 12'hFEE,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CL_W-1:0]   strap_cluster,
   input  logic [AG_W-1:0]   strap_agent,
   input  logic              strap_thread,
   input  logic              id_wr_en,
   input  logic [ID_W-1:0]   id_wr_data,
   input  logic              msg_valid,
   input  logic [ADDR_W-1:0] msg_addr,
   input  logic [DATA_W-1:0] msg_data,
   output logic              claim_valid,
   output logic [VEC_W-1:0]  claim_vector,
   output logic [MODE_W-1:0] claim_dlv_mode,
   output logic              claim_trigger,
   output logic              claim_bcast,
   output logic              unsup_mode
);
   localparam int DEST_LSB = ADDR_W - WIN_W - ID_W;

   if (ADDR_W < WIN_W + ID_W + 4) begin : g_bad_addr
      $error("irq_claim_unit: address too narrow for window and ID");
   end

   logic            in_window, logical, hit, bcast;
   logic [ID_W-1:0] dest_id, local_id;
   irq_fields_t     fields, fields_q;

   irq_msg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .WIN_W(WIN_W), .WIN_BASE(WIN_BASE)
   ) u_decode (
      .addr(msg_addr), .data(msg_data), .in_window(in_window),
      .logical(logical), .dest_id(dest_id), .fields(fields)
   );

   irq_local_id #(.ID_W(ID_W), .CL_W(CL_W), .AG_W(AG_W), .TH_W(1)) u_id (
      .clk(clk), .rst_n(rst_n), .strap_cluster(strap_cluster),
      .strap_agent(strap_agent), .strap_thread(strap_thread),
      .wr_en(id_wr_en), .wr_data(id_wr_data), .id_q(local_id)
   );

   irq_dest_match #(.ID_W(ID_W), .BCAST_EN(BCAST_EN)) u_match (
      .dest_id(dest_id), .local_id(local_id), .hit(hit), .bcast(bcast)
   );

   logic accept, take;
   assign accept = msg_valid & in_window;
   assign take   = accept & ~logical & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         claim_valid <= 1'b0;
         claim_bcast <= 1'b0;
         unsup_mode  <= 1'b0;
         fields_q    <= '0;
      end else begin
         claim_valid <= take;
         claim_bcast <= take & bcast;
         unsup_mode  <= accept & logical;
         fields_q    <= take ? fields : '0;
      end
   end

   assign claim_vector   = fields_q.vector;
   assign claim_dlv_mode = fields_q.dlv_mode;
   assign claim_trigger  = fields_q.trigger;

   // R1: claims only come from in-window addresses
   p_claim_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_valid || unsup_mode) |-> ($past(msg_addr[ADDR_W-1 -: WIN_W]) == WIN_BASE));
   // R10 / R12: every result traces back to a strobe one cycle earlier
   p_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_valid || unsup_mode) |-> $past(msg_valid));
   // R9: logical mode is never claimed
   p_logical_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_mode |-> (!claim_valid && $past(msg_addr[2])));
   // R4: broadcast flag only with a claim and an all-ones target
   p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      claim_bcast |-> (claim_valid && (&$past(msg_addr[DEST_LSB +: ID_W]))));
   // R3: fields are quiet without a claim
   p_quiet_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_valid |-> (fields_q == '0));
endmodule

// File: tb/sim_irq_claim_unit.sv
`timescale 1ns/1ps
module sim_irq_claim_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_cluster = 2'b10;
   logic [1:0]  strap_agent   = 2'b01;
   logic        strap_thread  = 1'b1;
   logic        id_wr_en = 1'b0;
   logic [7:0]  id_wr_data = '0;
   logic        msg_valid = 1'b0;
   logic [31:0] msg_addr = '0;
   logic [31:0] msg_data = '0;
   logic        claim_valid, claim_trigger, claim_bcast, unsup_mode;
   logic [7:0]  claim_vector;
   logic [2:0]  claim_dlv_mode;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R12 idle", exp_req = "R6 reset";

   irq_claim_unit u0 (
      .clk(clk), .rst_n(rst_n), .strap_cluster(strap_cluster),
      .strap_agent(strap_agent), .strap_thread(strap_thread),
      .id_wr_en(id_wr_en), .id_wr_data(id_wr_data), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data), .claim_valid(claim_valid),
      .claim_vector(claim_vector), .claim_dlv_mode(claim_dlv_mode),
      .claim_trigger(claim_trigger), .claim_bcast(claim_bcast),
      .unsup_mode(unsup_mode)
   );

   always #10 clk = ~clk;

   // behavioural reference
   logic [7:0] m_id;
   logic e_claim, e_unsup, e_bcast, e_trig;
   logic [7:0] e_vec;
   logic [2:0] e_mode;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_id = {3'b000, strap_cluster, strap_agent, strap_thread};
         e_claim = 0; e_unsup = 0; e_bcast = 0; e_trig = 0; e_vec = 0; e_mode = 0;
         exp_req = "R6 reset";
      end else begin
         bit inwin, tgt_all;
         inwin   = msg_valid && (msg_addr[31:20] == 12'hFEE);
         tgt_all = (msg_addr[19:12] == 8'hFF);
         e_unsup = inwin && msg_addr[2];
         e_claim = inwin && !msg_addr[2] && (tgt_all || msg_addr[19:12] == m_id);
         e_bcast = e_claim && tgt_all;
         e_vec   = e_claim ? msg_data[7:0]  : 8'h00;
         e_mode  = e_claim ? msg_data[10:8] : 3'h0;
         e_trig  = e_claim ? msg_data[15]   : 1'b0;
         exp_req = cur_req;
         if (id_wr_en) m_id = id_wr_data;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(exp_req, "claim_valid", 32'(claim_valid), 32'(e_claim));
         chk(exp_req, "unsup_mode", 32'(unsup_mode), 32'(e_unsup));
         chk(exp_req, "claim_bcast", 32'(claim_bcast), 32'(e_bcast));
         chk(exp_req, "claim_vector", 32'(claim_vector), 32'(e_vec));
         chk(exp_req, "claim_dlv_mode", 32'(claim_dlv_mode), 32'(e_mode));
         chk(exp_req, "claim_trigger", 32'(claim_trigger), 32'(e_trig));
      end
   end

   task automatic send(input logic [31:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = a; msg_data = d; id_wr_en = 1'b0; cur_req = req;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         msg_valid = 1'b0; id_wr_en = 1'b0; cur_req = "R12 idle";
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: outputs clear during reset
      chk("R6", "claim_valid in reset", 32'(claim_valid), 0);
      chk("R6", "unsup_mode in reset", 32'(unsup_mode), 0);
      chk("R6", "claim_vector in reset", 32'(claim_vector), 0);
      rst_n = 1'b1;
      idle(2);
      // R6: strap-built ID is 8'h13
      send(32'hFEE1_3000, 32'h0000_C5A5, "R6 strap id / R3 fields");
      idle(1);
      send(32'hFEE1_2000, 32'h0000_0101, "R6 neighbour id not claimed");
      send(32'hFEE1_3FF0, 32'h0000_8733, "R2 extended id ignored");
      send(32'hFEE1_4000, 32'h0000_0044, "R5 mismatch");
      send(32'hFEE1_3000, 32'h0000_4022, "R3 status bit ignored");
      send(32'hFEEF_F000, 32'h0000_8390, "R4 broadcast");
      send(32'hFED1_3000, 32'h0000_0011, "R1 outside window");
      send(32'h7EE1_3000, 32'h0000_0012, "R1 outside window high");
      send(32'hFEE1_3004, 32'h0000_0013, "R9 logical");
      send(32'hFEE1_3008, 32'h0000_0614, "R11 redirect hint");
      send(32'hFEE1_300C, 32'h0000_0615, "R9 logical with hint");
      idle(2);
      // R8: same-cycle write uses the old ID
      @(negedge clk);
      msg_valid = 1'b1; msg_addr = 32'hFEE1_3000; msg_data = 32'h0000_0777;
      id_wr_en = 1'b1; id_wr_data = 8'h5A; cur_req = "R8 write collision";
      send(32'hFEE5_A000, 32'h0000_8255, "R7 new id claimed");
      send(32'hFEE1_3000, 32'h0000_0256, "R7 old id dropped");
      send(32'hFEEF_F000, 32'h0000_0257, "R4 broadcast after write");
      idle(1);
      // R10: back-to-back results
      for (int i = 0; i < 6; i++)
         send(32'hFEE5_A000, 32'(i * 37 + 8'h10), "R10 back-to-back");
      idle(1);
      // R7: write 8'hFF makes directed and broadcast coincide
      @(negedge clk);
      msg_valid = 1'b0; id_wr_en = 1'b1; id_wr_data = 8'hFF; cur_req = "R7 write";
      send(32'hFEE5_A000, 32'h0000_0001, "R7 stale id after second write");
      idle(1);
      // mixed traffic
      for (int i = 0; i < 400; i++) begin
         int k;
         logic [31:0] a;
         k = int'($urandom % 5);
         a = $urandom;
         if (k != 4) a[31:20] = 12'hFEE;
         if (k == 0) a[19:12] = m_id;
         if (k == 1) a[19:12] = 8'hFF;
         if (k == 3) a[2] = 1'b0;
         @(negedge clk);
         msg_valid = ($urandom % 4) != 0; msg_addr = a; msg_data = $urandom;
         id_wr_en = ($urandom % 16) == 0; id_wr_data = 8'($urandom);
         cur_req = "R1/R5/R9/R12 mixed";
      end
      idle(3);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule